// File: doc/BRIEF.md
# Periodic Sequencer Start-Trigger Generator

This block produces the start pulse for a hardware sequencer that steps through its own states. It runs on a slow reference clock. In periodic mode it counts a period made of two programmable factors and a power-of-two prescale, and it issues one start pulse each time that period runs out. In repeat mode it ignores the period and restarts the sequencer one cycle after the sequencer reports that it has reached a stopping state.

Software may write new divider factors at any time. A write goes into a pending copy, and the counting period does not change during a count. The pending copy becomes active at the next start. It can also become active at the half-period checkpoint if no sequence is running at that point; in that case a start is issued at the checkpoint, which gives one shortened transitional interval. A test cycle can be requested, and it is injected as an extra start at the same checkpoint. Each start sets an interrupt flag. The flag stays set until software clears it.

Top module: `stg_start_gen`

## Requirements
- R1: During and directly after reset, `start_o` is 0, `state0_sel_o` is 1 and `irq_flag_o` is 0. The active period is `(DEF_A*DEF_B) << DEF_PRE` (16 with the default parameters), and the first start comes one full period after reset.
- R2: In periodic mode, consecutive regular `start_o` pulses are P reference cycles apart, where P = (`cfg_fac_a` * `cfg_fac_b`) << `cfg_pre_sel`. The `cfg_pre_sel` value k divides by 2^k: 0 gives /1, 1 gives /2, 2 gives /4 and 3 gives /8.
- R3: A computed period below 2, including any period whose factor is 0, is raised to 2 reference cycles.
- R4: A `cfg_we` pulse only loads the pending copy, so the count in progress keeps its period. If several writes arrive before the pending copy is used, the last one wins.
- R5: The half-period checkpoint is reached ceil(P/2) cycles after a start. If a write is pending there and no sequence is running, the new period becomes active and a start is issued at the checkpoint. Later starts use the new period.
- R6: If a sequence is still running at the checkpoint, the pending period waits and becomes active at the next regular start.
- R7: A `test_req` pulse causes one extra start at the next half-period checkpoint. The regular start times do not move.
- R8: While `rpt_en` is 1, `start_o` is high in the cycle after `seq_stop` is sampled high. If `rpt_en` is 1 while no sequence is running, a start is issued in the next cycle.
- R9: `irq_flag_o` is high in every cycle in which `start_o` is high, in both modes. A `flag_clr` pulse clears the flag in the next cycle. If a clear and a start fall in the same cycle, the start wins and the flag stays set.
- R10: `state0_sel_o` goes low together with `start_o`. It goes back high in the cycle after `seq_stop` is sampled high.
- R11: After `rpt_en` drops, the counter is held until `seq_stop` is sampled (or no sequence is running). It then reloads with the full period, and the next start comes P+1 cycles after that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Writes the factors and prescale into the pending copy |
| cfg_fac_a | input | A_W | First divider factor |
| cfg_fac_b | input | B_W | Second divider factor |
| cfg_pre_sel | input | PRE_W | Prescale select, divide by 2^value |
| rpt_en | input | 1 | Repeat mode enable |
| seq_stop | input | 1 | Sequencer has reached its stopping state |
| test_req | input | 1 | Requests a test-cycle start at the next checkpoint |
| flag_clr | input | 1 | Clears the start interrupt flag |
| start_o | output | 1 | One-cycle start pulse |
| state0_sel_o | output | 1 | Sequencer held at its first state (no sequence running) |
| irq_flag_o | output | 1 | Sticky start interrupt flag |

## Verification
Some rules are checked by the assertions on every cycle. These are: a restart follows a stop in repeat mode; the flag is set with every start and stays set until cleared; the sequencer-idle output falls with a start and rises only after a stop; the active period changes only at a start and never drops below two. Other behaviour can only be shown by the bench scenarios. This covers the exact spacing of starts under different factor and prescale settings, the shortened transitional interval after an idle checkpoint, and the deferral when a sequence overlaps the checkpoint. It also covers the extra test start and the full-period reload once repeat mode ends. For these, the bench compares against its cycle model and measures the start intervals.

// File: rtl/stg_pkg.sv
package stg_pkg;
    typedef enum logic {
        RUN_PERIODIC = 1'b0,
        RUN_REPEAT   = 1'b1
    } run_mode_e;
endpackage

// File: rtl/stg_period.sv
// Turns the factor pair and the prescale into one period in reference cycles.
module stg_period #(
    parameter int A_W   = 8,
    parameter int B_W   = 8,
    parameter int PRE_W = 2,
    parameter int P_W   = A_W + B_W + (2 ** PRE_W) - 1
) (
    input  logic [A_W-1:0]   fac_a,
    input  logic [B_W-1:0]   fac_b,
    input  logic [PRE_W-1:0] pre_sel,
    output logic [P_W-1:0]   period
);
    logic [P_W-1:0] product;
    logic [P_W-1:0] scaled;

    always_comb begin
        product = P_W'(fac_a) * P_W'(fac_b);
        scaled  = product << pre_sel;
        period  = (scaled < P_W'(2)) ? P_W'(2) : scaled;
    end
endmodule

// File: rtl/stg_shadow.sv
// Pending and active period registers; the pending value moves over only on take.
module stg_shadow #(
    parameter int             P_W        = 19,
    parameter logic [P_W-1:0] RST_PERIOD = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [P_W-1:0] wr_period,
    input  logic           take,
    output logic [P_W-1:0] act_period,
    output logic [P_W-1:0] pend_period,
    output logic           pend_valid
);
    typedef struct packed {
        logic [P_W-1:0] pend;
        logic           pv;
        logic [P_W-1:0] act;
    } shd_t;

    shd_t shd_d, shd_q;

    always_comb begin
        shd_d = shd_q;
        if (take && shd_q.pv) begin
            shd_d.act = shd_q.pend;
            shd_d.pv  = 1'b0;
        end
        if (wr) begin
            shd_d.pend = wr_period;
            shd_d.pv   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= '{pend: RST_PERIOD, pv: 1'b0, act: RST_PERIOD};
        end else begin
            shd_q <= shd_d;
        end
    end

    assign act_period  = shd_q.act;
    assign pend_period = shd_q.pend;
    assign pend_valid  = shd_q.pv;
endmodule

// File: rtl/stg_irq_flag.sv
// Sticky flag; a set in the same cycle as a clear keeps it high.
module stg_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set) begin
            flag_d = 1'b1;
        end else if (clr) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/stg_start_gen.sv
module stg_start_gen
    import stg_pkg::*;
#(
    parameter int A_W     = 8,
    parameter int B_W     = 8,
    parameter int PRE_W   = 2,
    parameter int DEF_A   = 4,
    parameter int DEF_B   = 4,
    parameter int DEF_PRE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [A_W-1:0]   cfg_fac_a,
    input  logic [B_W-1:0]   cfg_fac_b,
    input  logic [PRE_W-1:0] cfg_pre_sel,
    input  logic             rpt_en,
    input  logic             seq_stop,
    input  logic             test_req,
    input  logic             flag_clr,
    output logic             start_o,
    output logic             state0_sel_o,
    output logic             irq_flag_o
);
    localparam int P_W = A_W + B_W + (2 ** PRE_W) - 1;
    localparam int unsigned DEF_RAW = (DEF_A * DEF_B) << DEF_PRE;
    localparam logic [P_W-1:0] DEF_PERIOD = P_W'((DEF_RAW < 2) ? 2 : DEF_RAW);

    typedef struct packed {
        logic [P_W-1:0] cnt;
        run_mode_e      mode;
        logic           busy;
        logic           start;
        logic           tpend;
    } gen_state_t;

    logic [P_W-1:0] cfg_period;
    logic [P_W-1:0] act_period;
    logic [P_W-1:0] pend_period;
    logic           pend_valid;
    logic           fire;
    logic           take;
    logic           inj;
    logic           wrap;
    logic           half_pt;
    gen_state_t     st_d, st_q;

    stg_period #(
        .A_W  (A_W),
        .B_W  (B_W),
        .PRE_W(PRE_W),
        .P_W  (P_W)
    ) u_period (
        .fac_a  (cfg_fac_a),
        .fac_b  (cfg_fac_b),
        .pre_sel(cfg_pre_sel),
        .period (cfg_period)
    );

    stg_shadow #(
        .P_W       (P_W),
        .RST_PERIOD(DEF_PERIOD)
    ) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_we),
        .wr_period  (cfg_period),
        .take       (take),
        .act_period (act_period),
        .pend_period(pend_period),
        .pend_valid (pend_valid)
    );

    // Next-state logic: repeat mode, the hold after repeat ends, and periodic counting.
    always_comb begin
        st_d    = st_q;
        fire    = 1'b0;
        take    = 1'b0;
        inj     = 1'b0;
        wrap    = (st_q.cnt == '0);
        half_pt = (st_q.cnt == (act_period >> 1));

        if (rpt_en) begin
            st_d.mode = RUN_REPEAT;
            fire      = seq_stop || !st_q.busy;
            take      = fire;
        end else if (st_q.mode == RUN_REPEAT) begin
            if (seq_stop || !st_q.busy) begin
                st_d.mode = RUN_PERIODIC;
                st_d.cnt  = act_period - P_W'(1);
            end
        end else begin
            inj  = half_pt && st_q.tpend;
            take = wrap || (half_pt && pend_valid && !st_q.busy);
            fire = take || inj;
            if (take) begin
                st_d.cnt = (pend_valid ? pend_period : act_period) - P_W'(1);
            end else begin
                st_d.cnt = st_q.cnt - P_W'(1);
            end
        end

        if (fire) begin
            st_d.busy = 1'b1;
        end else if (seq_stop) begin
            st_d.busy = 1'b0;
        end
        st_d.start = fire;
        st_d.tpend = (st_q.tpend && !inj) || test_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: DEF_PERIOD - P_W'(1), mode: RUN_PERIODIC,
                      busy: 1'b0, start: 1'b0, tpend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    stg_irq_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (fire),
        .clr  (flag_clr),
        .flag (irq_flag_o)
    );

    assign start_o      = st_q.start;
    assign state0_sel_o = !st_q.busy;
endmodule

// File: rtl/stg_start_gen_chk.sv
module stg_start_gen_chk #(
    parameter int P_W = 19
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rpt_en,
    input logic           seq_stop,
    input logic           flag_clr,
    input logic           start_o,
    input logic           state0_sel_o,
    input logic           irq_flag_o,
    input logic [P_W-1:0] act_period
);
    // R8
    a_r8_repeat_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_en && seq_stop |=> start_o);

    // R9
    a_r9_flag_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> irq_flag_o);

    // R9
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag_o && !flag_clr |=> irq_flag_o);

    // R10
    a_r10_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !state0_sel_o);

    // R10
    a_r10_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state0_sel_o) |-> $past(seq_stop));

    // R4
    a_r4_active_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_period) |-> start_o);

    // R3
    a_r3_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        act_period >= P_W'(2));
endmodule

bind stg_start_gen stg_start_gen_chk #(.P_W(P_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rpt_en      (rpt_en),
    .seq_stop    (seq_stop),
    .flag_clr    (flag_clr),
    .start_o     (start_o),
    .state0_sel_o(state0_sel_o),
    .irq_flag_o  (irq_flag_o),
    .act_period  (act_period)
);

// File: tb/stg_start_gen_bench.sv
`timescale 1ns/1ps
module stg_start_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_fac_a = 8'd0;
    logic [7:0] cfg_fac_b = 8'd0;
    logic [1:0] cfg_pre_sel = 2'd0;
    logic       rpt_en = 1'b0;
    logic       seq_stop = 1'b0;
    logic       test_req = 1'b0;
    logic       flag_clr = 1'b0;
    logic       start_o, state0_sel_o, irq_flag_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int seq_len = 3;
    int left = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    int m_cnt = 15, m_act = 16, m_pend = 16;
    bit m_pv = 0, m_busy = 0, m_start = 0, m_flag = 0, m_tp = 0, m_rep = 0;

    always #5 clk = ~clk;

    stg_start_gen u_stg_start_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fac_a(cfg_fac_a),
        .cfg_fac_b(cfg_fac_b), .cfg_pre_sel(cfg_pre_sel), .rpt_en(rpt_en),
        .seq_stop(seq_stop), .test_req(test_req), .flag_clr(flag_clr),
        .start_o(start_o), .state0_sel_o(state0_sel_o), .irq_flag_o(irq_flag_o)
    );

    function automatic int period_of(int a, int b, int s);
        int raw = (a * b) << s;
        return (raw < 2) ? 2 : raw;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // cycle model, stepped on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 15; m_act = 16; m_pend = 16; m_pv = 0; m_busy = 0;
            m_start = 0; m_flag = 0; m_tp = 0; m_rep = 0;
        end else begin
            automatic bit f = 0, tk = 0, ij = 0;
            automatic int half = m_act / 2;
            if (rpt_en) begin
                m_rep = 1; f = seq_stop || !m_busy; tk = f;
            end else if (m_rep) begin
                if (seq_stop || !m_busy) begin m_rep = 0; m_cnt = m_act - 1; end
            end else begin
                ij = (m_cnt == half) && m_tp;
                tk = (m_cnt == 0) || ((m_cnt == half) && m_pv && !m_busy);
                f = tk || ij;
                m_cnt = tk ? ((m_pv ? m_pend : m_act) - 1) : (m_cnt - 1);
            end
            if (tk && m_pv) begin m_act = m_pend; m_pv = 0; end
            if (cfg_we) begin m_pend = period_of(cfg_fac_a, cfg_fac_b, cfg_pre_sel); m_pv = 1; end
            m_tp = (m_tp && !ij) || test_req;
            m_busy = f ? 1'b1 : (seq_stop ? 1'b0 : m_busy);
            m_flag = f ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
            m_start = f;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(start_o == m_start, {cur_req, " start_o"}, start_o, m_start);
            chk(state0_sel_o == !m_busy, {cur_req, " state0_sel_o"}, state0_sel_o, !m_busy);
            chk(irq_flag_o == m_flag, {cur_req, " irq_flag_o"}, irq_flag_o, m_flag);
        end
    end

    // simple sequencer: stop is reported seq_len cycles after each start
    always @(negedge clk) begin
        if (!rst_n) begin
            left = 0; seq_stop = 1'b0;
        end else if (start_o) begin
            left = seq_len; seq_stop = 1'b0;
        end else if (left > 0) begin
            left = left - 1; seq_stop = (left == 0);
        end else begin
            seq_stop = 1'b0;
        end
    end

    task automatic wait_start(output int t);
        @(negedge clk);
        while (!start_o) @(negedge clk);
        t = cyc;
    endtask

    task automatic set_cfg(int a, int b, int s);
        cfg_fac_a = 8'(a); cfg_fac_b = 8'(b); cfg_pre_sel = 2'(s); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic gap_after(int n_skip, int exp, string req);
        int ta, tb;
        for (int i = 0; i < n_skip; i++) wait_start(ta);
        wait_start(ta);
        wait_start(tb);
        chk(tb - ta == exp, req, tb - ta, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int t0, t1, t2, t3, t4, t5, t6, s, sa, sb, sc, sd, se, sf;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(start_o == 0, "R1 start", start_o, 0);
        chk(state0_sel_o == 1, "R1 state0", state0_sel_o, 1);
        chk(irq_flag_o == 0, "R1 flag", irq_flag_o, 0);
        rst_n = 1'b1;
        t0 = cyc;
        wait_start(t1);
        chk(t1 - t0 == 16, "R1 first start", t1 - t0, 16);

        // R2: default period 16
        cur_req = "R2";
        wait_start(t1);
        chk(t1 - t0 >= 0, "R2", 1, 1);
        wait_start(t2);
        chk(t2 - t1 == 16, "R2 default period", t2 - t1, 16);

        // R5: write right after a start with the sequencer idle at the checkpoint
        cur_req = "R5";
        set_cfg(3, 5, 1);
        wait_start(t3);
        chk(t3 - t2 == 8, "R5 transitional interval", t3 - t2, 8);
        cur_req = "R2";
        wait_start(t4);
        chk(t4 - t3 == 30, "R2 prescale /2 period", t4 - t3, 30);

        // R4 and R6: long sequence overlaps the checkpoint; two writes, last wins
        cur_req = "R6";
        seq_len = 20;
        wait_start(t4);
        set_cfg(10, 10, 0);
        set_cfg(2, 2, 0);
        wait_start(t5);
        chk(t5 - t4 == 30, "R6 deferred to regular start", t5 - t4, 30);
        cur_req = "R4";
        wait_start(t6);
        chk(t6 - t5 == 4, "R4 last write wins", t6 - t5, 4);

        // R3 clamp and R2 period formula
        cur_req = "R3";
        seq_len = 2;
        set_cfg(0, 9, 3);
        gap_after(2, 2, "R3 zero factor clamp");
        cur_req = "R2";
        set_cfg(2, 3, 0);
        gap_after(2, 6, "R2 period 2*3");
        cur_req = "R3";
        set_cfg(1, 1, 0);
        gap_after(2, 2, "R3 unit product clamp");

        // R7, R9, R10 in periodic mode with period 20
        cur_req = "R7";
        set_cfg(4, 5, 0);
        for (int i = 0; i < 3; i++) wait_start(s);
        wait_start(s);
        chk(state0_sel_o == 0, "R10 low with start", state0_sel_o, 0);
        chk(irq_flag_o == 1, "R9 set with start", irq_flag_o, 1);
        test_req = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        chk(irq_flag_o == 0, "R9 cleared", irq_flag_o, 0);
        test_req = 1'b0; flag_clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(state0_sel_o == 1, "R10 high after stop", state0_sel_o, 1);
        wait_start(t1);
        chk(t1 - s == 10, "R7 injected start at checkpoint", t1 - s, 10);
        wait_start(t2);
        chk(t2 - s == 20, "R7 regular start unchanged", t2 - s, 20);

        // R8 repeat mode
        cur_req = "R8";
        seq_len = 4;
        wait_start(sa);
        rpt_en = 1'b1;
        wait_start(sb);
        chk(sb - sa == 5, "R8 restart after stop", sb - sa, 5);
        wait_start(sc);
        chk(sc - sb == 5, "R8 repeat spacing", sc - sb, 5);

        // R9 clear and start in the same cycle
        cur_req = "R9";
        repeat (3) @(negedge clk);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        sd = cyc;
        chk(start_o == 1, "R9 start in clear cycle", start_o, 1);
        chk(irq_flag_o == 1, "R9 start wins over clear", irq_flag_o, 1);
        flag_clr = 1'b0;

        // R11 leaving repeat mode
        cur_req = "R11";
        rpt_en = 1'b0;
        wait_start(se);
        chk(se - sd == 25, "R11 resume with full reload", se - sd, 25);
        cur_req = "R2";
        wait_start(sf);
        chk(sf - se == 20, "R2 periodic after resume", sf - se, 20);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule